// File: doc/BRIEF.md
# Register-Mapped Parallel LCD Bus Bridge

This block is an APB slave that turns register accesses into timed cycles on a parallel LCD controller bus. The bus has one chip select, a line that chooses between the controller's command register and its data RAM, separate write and read strobes, and a 16-bit data bus. The data bus is split here into an output half, an output enable and an input half, so the pad ring can build the bidirectional pin. One register offset carries commands. A second offset carries panel RAM data. A third holds a sticky completion flag that software clears, and this flag also drives an interrupt line.

The sequencer drives each bus cycle through four phases: address setup, strobe active, hold, and a one-cycle completion step. Parameters set the length of the first three phases in bus clocks. A write or data read starts as soon as the APB access phase completes. That access phase has no wait states while the sequencer is idle. If a new access arrives while a bus cycle is still in progress, the block holds it off with `pready` low. Data read from panel RAM is captured on the last clock of the read strobe. A later read of the data offset returns that captured value, so a panel read takes two accesses: the first starts the cycle and the second collects the result.

Top module: `lcd_pbus_bridge`

## Requirements
- R1: An accepted APB write to byte offset 0x0 produces one bus cycle with `lcd_rs` low, one write-strobe pulse, `lcd_doe` high, `lcd_dout` equal to `pwdata[15:0]`, and `lcd_rd_n` held high.
- R2: An accepted APB write to byte offset 0x4 produces one bus cycle with `lcd_rs` high, one write-strobe pulse and `lcd_dout` equal to `pwdata[15:0]`.
- R3: An accepted APB read of offset 0x4 produces one bus cycle with `lcd_rs` high, a read-strobe pulse and `lcd_doe` low. The value on `lcd_din` in the last strobe clock is captured. Every read of offset 0x4 returns the most recently captured value in `prdata[15:0]`, with the upper bits zero. The captured value is 0 after reset.
- R4: A read of offset 0x0 returns `lcd_busy` in bit 0 and zeros above it, and starts no bus cycle.
- R5: In each bus cycle, `lcd_cs_n` is low for exactly SETUP_CYC clocks before the strobe, the strobe is low for exactly STROBE_CYC clocks, and `lcd_cs_n` stays low for exactly HOLD_CYC clocks after it. The two strobes are never low together, and data and the select line do not change while a write strobe is low.
- R6: Bit 0 of offset 0x8 is the completion flag. It becomes 1 after every finished bus cycle, write or read. It goes back to 0 only on a write to offset 0x8 with bit 0 clear; a write with bit 0 set leaves it unchanged. `irq` equals the flag.
- R7: Bits 31:1 of offset 0x8 read as zero. Any other word offset reads as zero, and writes to it start no bus cycle.
- R8: While no bus cycle is in progress, `pready` is high, so an access phase completes in one clock. From the start of a bus cycle until its completion step, `pready` is low for any access. The held access then completes and takes effect.
- R9: During and after reset, `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are high, `lcd_doe` and `irq` are low, and `pready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address; bits 1:0 ignored |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready; low holds off an access while a bus cycle runs |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data RAM |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dout | output | 16 | Data driven toward the panel |
| lcd_doe | output | 1 | Output enable for `lcd_dout` |
| lcd_din | input | 16 | Data returned by the panel |
| lcd_busy | input | 1 | Panel busy status |
| irq | output | 1 | Completion interrupt, high while the flag is set |

## Verification
A sequencer stuck in a phase or moving on too early changes the setup, strobe or hold counts of the very next bus cycle. It also leaves `pready` low past the completion step, so the next queued access stalls longer than it should. A capture taken on the wrong clock shows up on the following read of the data offset, because the panel model drives a marker value outside the strobe. A flag that sets late or misses its clear appears on `irq` within one clock of the cycle's end, or on the next flag read.

// File: rtl/lcd_pbus_pkg.sv
package lcd_pbus_pkg;

    localparam int LCD_DW = 16;

    // word offsets (byte offset >> 2)
    localparam int WOFS_CMD  = 0;
    localparam int WOFS_DATA = 1;
    localparam int WOFS_FLAG = 2;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_STROBE,
        SQ_HOLD,
        SQ_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_CMD_WR,
        OP_DAT_WR,
        OP_DAT_RD
    } bus_op_e;

    typedef struct packed {
        bus_op_e           op;
        logic [LCD_DW-1:0] wdata;
    } bus_req_t;

    function automatic logic op_is_read(bus_op_e op);
        return op == OP_DAT_RD;
    endfunction

    function automatic logic op_is_data(bus_op_e op);
        return op != OP_CMD_WR;
    endfunction

endpackage

// File: rtl/lcd_pbus_apb_dec.sv
module lcd_pbus_apb_dec
    import lcd_pbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              seq_busy,
    input  logic              panel_busy,
    input  logic              flag,
    input  logic [LCD_DW-1:0] rd_latch,
    output logic              pready,
    output logic [DATA_W-1:0] prdata,
    output logic              start,
    output bus_req_t          req,
    output logic              flag_clr
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              fire;
    logic              hit_cmd, hit_data, hit_flag;
    logic              unused_bits;

    assign word     = paddr[ADDR_W-1:2];
    assign hit_cmd  = (word == WORD_W'(WOFS_CMD));
    assign hit_data = (word == WORD_W'(WOFS_DATA));
    assign hit_flag = (word == WORD_W'(WOFS_FLAG));

    assign pready = !seq_busy;
    assign fire   = psel && penable && !seq_busy;

    assign start    = fire && (hit_data || (pwrite && hit_cmd));
    assign flag_clr = fire && pwrite && hit_flag && !pwdata[0];

    always_comb begin
        if (!pwrite)
            req.op = OP_DAT_RD;
        else if (hit_cmd)
            req.op = OP_CMD_WR;
        else
            req.op = OP_DAT_WR;
        req.wdata = pwdata[LCD_DW-1:0];
    end

    always_comb begin
        prdata = '0;
        if (hit_cmd)
            prdata[0] = panel_busy;
        else if (hit_data)
            prdata[LCD_DW-1:0] = rd_latch;
        else if (hit_flag)
            prdata[0] = flag;
    end

    assign unused_bits = ^{paddr[1:0], pwdata[DATA_W-1:LCD_DW]};

endmodule

// File: rtl/lcd_pbus_seq.sv
module lcd_pbus_seq
    import lcd_pbus_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bus_req_t          req,
    input  logic [LCD_DW-1:0] lcd_din,
    output logic              busy,
    output logic              done,
    output logic              lcd_cs_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic [LCD_DW-1:0] lcd_dout,
    output logic              lcd_doe,
    output logic [LCD_DW-1:0] rd_data
);

    localparam int LONG_A  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int LONGEST = (LONG_A > HOLD_CYC) ? LONG_A : HOLD_CYC;
    localparam int CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    bus_req_t          req_q;
    logic [LCD_DW-1:0] rdat_q;
    int                phase_len;
    logic              phase_end;
    logic              in_cycle;
    logic              is_rd;

    always_comb begin
        unique case (state_q)
            SQ_SETUP:  phase_len = SETUP_CYC;
            SQ_STROBE: phase_len = STROBE_CYC;
            SQ_HOLD:   phase_len = HOLD_CYC;
            default:   phase_len = 1;
        endcase
        phase_end = (cnt_q == CNT_W'(phase_len - 1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (start)     state_d = SQ_SETUP;
            SQ_SETUP:  if (phase_end) state_d = SQ_STROBE;
            SQ_STROBE: if (phase_end) state_d = SQ_HOLD;
            SQ_HOLD:   if (phase_end) state_d = SQ_DONE;
            SQ_DONE:                  state_d = SQ_IDLE;
            default:                  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            req_q   <= '{op: OP_CMD_WR, wdata: '0};
            rdat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || state_q == SQ_IDLE)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
            if (state_q == SQ_IDLE && start)
                req_q <= req;
            if (state_q == SQ_STROBE && phase_end && op_is_read(req_q.op))
                rdat_q <= lcd_din;
        end
    end

    assign is_rd    = op_is_read(req_q.op);
    assign in_cycle = (state_q == SQ_SETUP) || (state_q == SQ_STROBE) || (state_q == SQ_HOLD);

    assign busy     = (state_q != SQ_IDLE);
    assign done     = (state_q == SQ_DONE);
    assign lcd_cs_n = !in_cycle;
    assign lcd_rs   = op_is_data(req_q.op);
    assign lcd_wr_n = !(state_q == SQ_STROBE && !is_rd);
    assign lcd_rd_n = !(state_q == SQ_STROBE && is_rd);
    assign lcd_dout = req_q.wdata;
    assign lcd_doe  = in_cycle && !is_rd;
    assign rd_data  = rdat_q;

endmodule

// File: rtl/lcd_pbus_flag.sv
module lcd_pbus_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/lcd_pbus_bridge.sv
module lcd_pbus_bridge
    import lcd_pbus_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int DATA_W     = 32,
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_CYC = 3,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              lcd_cs_n,
    output logic              lcd_rs,
    output logic              lcd_wr_n,
    output logic              lcd_rd_n,
    output logic [LCD_DW-1:0] lcd_dout,
    output logic              lcd_doe,
    input  logic [LCD_DW-1:0] lcd_din,
    input  logic              lcd_busy,
    output logic              irq
);

    logic              seq_busy, seq_done, start, flag_clr, flag;
    bus_req_t          req;
    logic [LCD_DW-1:0] rd_latch;

    lcd_pbus_apb_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
        .pwdata(pwdata), .seq_busy(seq_busy), .panel_busy(lcd_busy),
        .flag(flag), .rd_latch(rd_latch), .pready(pready), .prdata(prdata),
        .start(start), .req(req), .flag_clr(flag_clr)
    );

    lcd_pbus_seq #(.SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk(clk), .rst(rst), .start(start), .req(req), .lcd_din(lcd_din),
        .busy(seq_busy), .done(seq_done), .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs),
        .lcd_wr_n(lcd_wr_n), .lcd_rd_n(lcd_rd_n), .lcd_dout(lcd_dout),
        .lcd_doe(lcd_doe), .rd_data(rd_latch)
    );

    lcd_pbus_flag u_flag (
        .clk(clk), .rst(rst), .set(seq_done), .clr(flag_clr), .flag(flag)
    );

    assign irq = flag;

endmodule

// File: rtl/lcd_pbus_chk.sv
module lcd_pbus_chk
    import lcd_pbus_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              psel,
    input logic              penable,
    input logic              pready,
    input logic              lcd_cs_n,
    input logic              lcd_rs,
    input logic              lcd_wr_n,
    input logic              lcd_rd_n,
    input logic [LCD_DW-1:0] lcd_dout,
    input logic              lcd_doe,
    input logic              irq
);

    // R1 R2
    wr_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !lcd_wr_n |-> !lcd_cs_n);

    // R3
    rd_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !lcd_rd_n |-> !lcd_cs_n);

    // R3
    rd_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !lcd_rd_n |-> !lcd_doe);

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        lcd_wr_n || lcd_rd_n);

    // R5
    wr_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!lcd_wr_n && $past(!lcd_wr_n)) |-> ($stable(lcd_dout) && $stable(lcd_rs)));

    // R8
    busy_holdoff_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && !lcd_cs_n) |-> !pready);

    // R6
    irq_after_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(lcd_cs_n) && !$past(lcd_cs_n, 2)));

endmodule

bind lcd_pbus_bridge lcd_pbus_chk u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pready(pready),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n),
    .lcd_rd_n(lcd_rd_n), .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .irq(irq)
);

// File: tb/lcd_pbus_bridge_tb.sv
module lcd_pbus_bridge_tb;

    localparam int SU = 2, ST = 3, HO = 1;

    logic        clk = 1'b0, rst = 1'b1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0, prdata;
    logic        pready, lcd_cs_n, lcd_rs, lcd_wr_n, lcd_rd_n, lcd_doe, irq;
    logic [15:0] lcd_dout, lcd_din = 16'hDEAD;
    logic        lcd_busy = 1'b0;
    logic [15:0] rd_pattern = 16'h0000;

    int checks = 0, errors = 0;
    bit finished = 0;

    lcd_pbus_bridge #(.SETUP_CYC(SU), .STROBE_CYC(ST), .HOLD_CYC(HO)) u_dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n),
        .lcd_rd_n(lcd_rd_n), .lcd_dout(lcd_dout), .lcd_doe(lcd_doe),
        .lcd_din(lcd_din), .lcd_busy(lcd_busy), .irq(irq)
    );

    always #2 clk = ~clk;

    // panel model: marker value outside the read strobe
    always @(negedge clk) lcd_din <= !lcd_rd_n ? rd_pattern : 16'hDEAD;

    // bus monitor
    int su_n = 0, st_n = 0, ho_n = 0, tx_count = 0;
    int l_su, l_st, l_ho;
    bit saw_wr = 0, saw_rd = 0, l_wr, l_rd, l_rs, l_oe, prev_cs = 1;
    logic [15:0] cap_d, l_d;
    always @(negedge clk) begin
        if (!rst) begin
            if (!lcd_cs_n) begin
                if (!lcd_wr_n || !lcd_rd_n) begin
                    st_n++;
                    if (!lcd_wr_n) saw_wr = 1;
                    if (!lcd_rd_n) saw_rd = 1;
                    cap_d = lcd_dout; l_rs = lcd_rs; l_oe = lcd_doe;
                end else if (st_n == 0) su_n++;
                else ho_n++;
            end else if (!prev_cs) begin
                l_su = su_n; l_st = st_n; l_ho = ho_n; l_wr = saw_wr; l_rd = saw_rd; l_d = cap_d;
                su_n = 0; st_n = 0; ho_n = 0; saw_wr = 0; saw_rd = 0;
                tx_count++;
            end
            prev_cs = lcd_cs_n;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb(input bit wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output int waits);
        waits = 0;
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        #1;
        while (!pready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        rd = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic wait_tx(int target);
        while (tx_count < target) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] r; int w;
        chk("R9 cs_n", lcd_cs_n, 1); chk("R9 wr_n", lcd_wr_n, 1);
        chk("R9 rd_n", lcd_rd_n, 1); chk("R9 doe", lcd_doe, 0);
        chk("R9 irq", irq, 0); chk("R9 pready", pready, 1);
        apb(0, 12'h008, 0, r, w);
        chk("R9 flag read", r, 0);
    endtask

    task automatic t_cmd_write();
        logic [31:0] r; int w; int n = tx_count;
        apb(1, 12'h000, 32'h1234_A5C3, r, w);
        chk("R8 no wait when idle", w, 0);
        wait_tx(n + 1);
        chk("R1 rs", l_rs, 0); chk("R1 write strobe", l_wr, 1);
        chk("R1 no read strobe", l_rd, 0); chk("R1 data", l_d, 16'hA5C3);
        chk("R1 doe", l_oe, 1);
        chk("R5 setup", l_su, SU); chk("R5 strobe", l_st, ST); chk("R5 hold", l_ho, HO);
        chk("R6 irq after write", irq, 1);
    endtask

    task automatic t_flag();
        logic [31:0] r; int w;
        apb(1, 12'h008, 32'h1, r, w);
        apb(0, 12'h008, 0, r, w);
        chk("R6 write one keeps flag, R7 upper zero", r, 1);
        apb(1, 12'h008, 32'hFFFF_FFFE, r, w);
        apb(0, 12'h008, 0, r, w);
        chk("R6 clear", r, 0);
        chk("R6 irq cleared", irq, 0);
    endtask

    task automatic t_data_write();
        logic [31:0] r; int w; int n = tx_count;
        apb(1, 12'h004, 32'hFFFF_BEEF, r, w);
        wait_tx(n + 1);
        chk("R2 rs", l_rs, 1); chk("R2 write strobe", l_wr, 1);
        chk("R2 data", l_d, 16'hBEEF);
        chk("R5 strobe width data", l_st, ST);
        chk("R6 irq after data write", irq, 1);
        apb(1, 12'h008, 0, r, w);
    endtask

    task automatic t_data_read();
        logic [31:0] r; int w; int n = tx_count;
        rd_pattern = 16'h5A3C;
        apb(0, 12'h004, 0, r, w);
        chk("R3 first read returns prior latch", r, 0);
        wait_tx(n + 1);
        chk("R3 rs", l_rs, 1); chk("R3 read strobe", l_rd, 1);
        chk("R3 no write strobe", l_wr, 0); chk("R3 doe low", l_oe, 0);
        chk("R6 irq after read", irq, 1);
        rd_pattern = 16'h0F0F;
        apb(0, 12'h004, 0, r, w);
        chk("R3 latched value", r, 32'h0000_5A3C);
        wait_tx(n + 2);
        apb(1, 12'h008, 0, r, w);
        apb(0, 12'h004, 0, r, w);
        chk("R3 second latch", r, 32'h0000_0F0F);
        wait_tx(n + 3);
    endtask

    task automatic t_busy();
        logic [31:0] r; int w; int n = tx_count;
        lcd_busy = 1;
        apb(0, 12'h000, 0, r, w);
        chk("R4 busy high", r, 1);
        lcd_busy = 0;
        apb(0, 12'h000, 0, r, w);
        chk("R4 busy low", r, 0);
        repeat (10) @(negedge clk);
        chk("R4 no bus cycle", tx_count, n);
    endtask

    task automatic t_holdoff();
        logic [31:0] r; int w; int n = tx_count;
        apb(1, 12'h000, 32'h0000_0011, r, w);
        apb(1, 12'h004, 32'h0000_7E57, r, w);
        chk("R8 held off", (w > 0), 1);
        wait_tx(n + 2);
        chk("R8 held write executed", l_d, 16'h7E57);
        chk("R8 held write rs", l_rs, 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] r; int w; int n = tx_count;
        apb(1, 12'h010, 32'hFFFF_FFFF, r, w);
        apb(1, 12'h00C, 32'h0000_0000, r, w);
        repeat (12) @(negedge clk);
        chk("R7 no bus cycle on unmapped write", tx_count, n);
        apb(0, 12'h010, 0, r, w);
        chk("R7 unmapped reads zero", r, 0);
        apb(0, 12'h00C, 0, r, w);
        chk("R7 offset C reads zero", r, 0);
        chk("R7 flag untouched", irq, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 0;
        repeat (2) @(negedge clk);
        t_reset();
        t_cmd_write();
        t_flag();
        t_data_write();
        t_data_read();
        t_busy();
        t_holdoff();
        t_unmapped();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule